// File: doc/BRIEF.md
# Dual-Source Push-Button Reset Combiner

This block drives one active-low system reset from two independent request channels and a supply monitor. The first channel reacts at once: a rising edge on an active-high request line fires a reset pulse with no setup delay. Once that pulse has finished, the request line has to fall, and a debounce lockout then runs. Any rising edge that arrives during the lockout is dropped. The second channel is a single long-press button, active low. It fires the same length of pulse only when the button has been held for a setup time chosen by a strap, so a short press never resets the system.

An undervoltage flag pulls the reset low in the same cycle it is raised. It keeps the reset low for one reset period after the flag clears. All periods are counted in cycles of a tick enable, so the wide lockout and setup times cost only a small counter. The request line and the button are expected to be synchronized to the clock already.

Top module: `dual_src_reset`

## Requirements
- R1: While rst_ni is low, and after it is released with all inputs idle (uv_i low, btn_ni high, req_i low), rst_no is high.
- R2: A rising edge of req_i seen while the edge channel is idle drives rst_no low from the next clock. It holds rst_no low for exactly REC_TICKS ticks.
- R3: A further rising edge of req_i while the edge pulse is active neither extends nor restarts that pulse.
- R4: When the pulse ends, a lockout of DEB_TICKS ticks begins at once if req_i is low. If req_i is high, the lockout begins on its next falling edge. Rising edges before the lockout ends produce no reset.
- R5: The first rising edge of req_i after the lockout has expired fires a new pulse of REC_TICKS ticks.
- R6: With btn_ni held low, a pulse of REC_TICKS ticks starts on the tick where the hold reaches the setup time. The setup time is SETUP0_TICKS for sel_i=2'b00, SETUP1_TICKS for sel_i=2'b01, and SETUP2_TICKS for sel_i=2'b10 or 2'b11. A press one tick shorter produces no reset.
- R7: Holding btn_ni low beyond the pulse produces no second pulse until the button has been released.
- R8: uv_i high drives rst_no low in the same cycle. After uv_i falls, rst_no stays low for REC_TICKS further ticks.
- R9: Pulse, lockout, setup and hold-off counters advance only in cycles where tick_i is high.
- R10: The two channels run independently: an edge request fires immediately even while the button is held, and any one active source holds rst_no low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Time-base enable; counters step on cycles where it is high |
| req_i | input | 1 | Edge-triggered reset request, active high, synchronized |
| btn_ni | input | 1 | Long-press button, active low, synchronized |
| sel_i | input | 2 | Setup-time strap for the button channel |
| uv_i | input | 1 | Undervoltage flag, active high |
| rst_no | output | 1 | Combined reset output, active low |

## Verification
An edge request is seen on rst_no one clock after the edge that samples it. The button pulse appears after the SETUP-th ticking edge of the hold. The undervoltage flag acts combinationally, so it is checked one time unit after it is driven. Inputs change on falling clock edges and rst_no is sampled on falling edges only. Each result is therefore read exactly one rising edge after the stimulus that caused it. Pulse widths and ignored edges are judged by counting low samples over a window longer than the expected pulse, and that count must equal REC_TICKS, REC_TICKS-1 when the tick was paused after the trigger, or zero.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  typedef enum logic [1:0] {EDGE_IDLE, EDGE_PULSE, EDGE_WAIT_LOW, EDGE_LOCK} edge_state_e;
  typedef enum logic [1:0] {HOLD_IDLE, HOLD_PULSE, HOLD_WAIT_REL} hold_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/dsr_tick_timer.sv
module dsr_tick_timer #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          start_i,
  input  logic [CW-1:0] len_i,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (start_i)                     cnt_q <= len_i;
    else if (tick_i && cnt_q != '0)       cnt_q <= cnt_q - CW'(1);
  end

  // last tick of the loaded period
  assign done_o = tick_i && (cnt_q == CW'(1));
endmodule

// File: rtl/dsr_edge_chan.sv
module dsr_edge_chan
  import dsr_pkg::*;
#(
  parameter int CW        = 8,
  parameter int REC_TICKS = 14,
  parameter int DEB_TICKS = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic req_i,
  output logic act_o,
  output logic busy_o
);
  edge_state_e st_q, st_d;
  logic req_q, rise;
  logic pulse_start, pulse_done, lock_start, lock_done;

  assign rise = req_i & ~req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= EDGE_IDLE;
      req_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      req_q <= req_i;
    end
  end

  always_comb begin
    st_d        = st_q;
    pulse_start = 1'b0;
    lock_start  = 1'b0;
    case (st_q)
      EDGE_IDLE: if (rise) begin
        pulse_start = 1'b1;
        st_d        = EDGE_PULSE;
      end
      EDGE_PULSE: if (pulse_done) begin
        if (req_i) st_d = EDGE_WAIT_LOW;
        else begin
          lock_start = 1'b1;
          st_d       = EDGE_LOCK;
        end
      end
      EDGE_WAIT_LOW: if (!req_i) begin
        lock_start = 1'b1;
        st_d       = EDGE_LOCK;
      end
      EDGE_LOCK: if (lock_done) st_d = EDGE_IDLE;
      default: st_d = EDGE_IDLE;
    endcase
  end

  dsr_tick_timer #(.CW(CW)) u_pulse (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
    .start_i(pulse_start), .len_i(CW'(REC_TICKS)), .done_o(pulse_done)
  );

  dsr_tick_timer #(.CW(CW)) u_lock (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
    .start_i(lock_start), .len_i(CW'(DEB_TICKS)), .done_o(lock_done)
  );

  assign act_o  = (st_q == EDGE_PULSE);
  assign busy_o = (st_q != EDGE_IDLE);
endmodule

// File: rtl/dsr_hold_chan.sv
module dsr_hold_chan
  import dsr_pkg::*;
#(
  parameter int CW           = 8,
  parameter int REC_TICKS    = 14,
  parameter int SETUP0_TICKS = 20,
  parameter int SETUP1_TICKS = 60,
  parameter int SETUP2_TICKS = 100
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       btn_ni,
  input  logic [1:0] sel_i,
  output logic       act_o
);
  hold_state_e   st_q, st_d;
  logic [CW-1:0] press_q, press_d, setup_len;
  logic          pulse_start, pulse_done;

  always_comb begin
    case (sel_i)
      2'b00:   setup_len = CW'(SETUP0_TICKS);
      2'b01:   setup_len = CW'(SETUP1_TICKS);
      default: setup_len = CW'(SETUP2_TICKS);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= HOLD_IDLE;
      press_q <= '0;
    end else begin
      st_q    <= st_d;
      press_q <= press_d;
    end
  end

  always_comb begin
    st_d        = st_q;
    press_d     = press_q;
    pulse_start = 1'b0;
    case (st_q)
      HOLD_IDLE: begin
        if (btn_ni) press_d = '0;
        else if (tick_i) begin
          // >= keeps a strap change mid-press from stalling the count
          if (press_q >= setup_len - CW'(1)) begin
            press_d     = '0;
            pulse_start = 1'b1;
            st_d        = HOLD_PULSE;
          end else begin
            press_d = press_q + CW'(1);
          end
        end
      end
      HOLD_PULSE:    if (pulse_done) st_d = HOLD_WAIT_REL;
      HOLD_WAIT_REL: if (btn_ni) begin
        press_d = '0;
        st_d    = HOLD_IDLE;
      end
      default: st_d = HOLD_IDLE;
    endcase
  end

  dsr_tick_timer #(.CW(CW)) u_pulse (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
    .start_i(pulse_start), .len_i(CW'(REC_TICKS)), .done_o(pulse_done)
  );

  assign act_o = (st_q == HOLD_PULSE);
endmodule

// File: rtl/dsr_uv_hold.sv
module dsr_uv_hold #(
  parameter int CW        = 8,
  parameter int REC_TICKS = 14
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic uv_i,
  output logic act_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (uv_i)                  cnt_q <= CW'(REC_TICKS);
    else if (tick_i && cnt_q != '0) cnt_q <= cnt_q - CW'(1);
  end

  assign act_o = uv_i | (cnt_q != '0);
endmodule

// File: rtl/dual_src_reset.sv
module dual_src_reset
  import dsr_pkg::*;
#(
  parameter int REC_TICKS    = 14,
  parameter int DEB_TICKS    = 24,
  parameter int SETUP0_TICKS = 20,
  parameter int SETUP1_TICKS = 60,
  parameter int SETUP2_TICKS = 100
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       req_i,
  input  logic       btn_ni,
  input  logic [1:0] sel_i,
  input  logic       uv_i,
  output logic       rst_no
);
  localparam int MAX_TICKS = max2(max2(REC_TICKS, DEB_TICKS),
                                  max2(SETUP0_TICKS, max2(SETUP1_TICKS, SETUP2_TICKS)));
  localparam int CW = $clog2(MAX_TICKS + 1);

  logic edge_act, edge_busy, hold_act, uv_act;

  dsr_edge_chan #(.CW(CW), .REC_TICKS(REC_TICKS), .DEB_TICKS(DEB_TICKS)) u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .req_i(req_i),
    .act_o(edge_act), .busy_o(edge_busy)
  );

  dsr_hold_chan #(
    .CW(CW), .REC_TICKS(REC_TICKS),
    .SETUP0_TICKS(SETUP0_TICKS), .SETUP1_TICKS(SETUP1_TICKS), .SETUP2_TICKS(SETUP2_TICKS)
  ) u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .btn_ni(btn_ni),
    .sel_i(sel_i), .act_o(hold_act)
  );

  dsr_uv_hold #(.CW(CW), .REC_TICKS(REC_TICKS)) u_uv (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .uv_i(uv_i), .act_o(uv_act)
  );

  assign rst_no = ~(edge_act | hold_act | uv_act);
endmodule

// File: rtl/dual_src_reset_chk.sv
module dual_src_reset_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic req_i,
  input logic btn_ni,
  input logic uv_i,
  input logic rst_no,
  input logic edge_act,
  input logic edge_busy,
  input logic hold_act
);
  AST_UV_FORCES_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uv_i |-> !rst_no); // R8

  AST_EDGE_DRIVES_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_act |-> !rst_no); // R10

  AST_HOLD_DRIVES_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_act |-> !rst_no); // R10

  AST_EDGE_FIRES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(req_i) && !edge_busy) |=> edge_act); // R2

  AST_LOCK_NO_FIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_busy && !edge_act) |=> !edge_act); // R4

  AST_PULSE_WAITS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_act && !tick_i) |=> edge_act); // R9

  AST_HOLD_NEEDS_PRESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_act) |-> !$past(btn_ni)); // R6
endmodule

bind dual_src_reset dual_src_reset_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .req_i(req_i),
  .btn_ni(btn_ni), .uv_i(uv_i), .rst_no(rst_no),
  .edge_act(edge_act), .edge_busy(edge_busy), .hold_act(hold_act)
);

// File: tb/tb_dual_src_reset.sv
module tb_dual_src_reset;
  localparam int REC = 14;
  localparam int DEB = 24;
  localparam int S0  = 20;
  localparam int S1  = 60;
  localparam int S2  = 100;

  typedef struct packed {
    logic [1:0] sel;
    logic [7:0] len;
    logic [7:0] exp;
  } vec_t;

  // long-press vectors: strap, hold length in ticks, expected low samples
  localparam vec_t VECS [9] = '{
    '{2'd0, 8'd19,  8'd0},
    '{2'd0, 8'd20,  8'd14},
    '{2'd1, 8'd59,  8'd0},
    '{2'd1, 8'd60,  8'd14},
    '{2'd2, 8'd99,  8'd0},
    '{2'd2, 8'd100, 8'd14},
    '{2'd3, 8'd100, 8'd14},
    '{2'd3, 8'd99,  8'd0},
    '{2'd0, 8'd60,  8'd14}
  };

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b1;
  logic       req_i = 1'b0;
  logic       btn_ni = 1'b1;
  logic [1:0] sel_i = 2'b00;
  logic       uv_i = 1'b0;
  logic       rst_no;

  int checks = 0;
  int errors = 0;
  int lows   = 0;

  always #4 clk = ~clk;

  dual_src_reset #(
    .REC_TICKS(REC), .DEB_TICKS(DEB),
    .SETUP0_TICKS(S0), .SETUP1_TICKS(S1), .SETUP2_TICKS(S2)
  ) dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .req_i(req_i),
    .btn_ni(btn_ni), .sel_i(sel_i), .uv_i(uv_i), .rst_no(rst_no)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one rising edge, then sample at the falling edge
  task automatic run(input int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
      if (!rst_no) lows++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 output during reset", rst_no, 1);
    rst_ni = 1'b1;
    run(3);
    chk("R1 output after reset", rst_no, 1);

    for (int i = 0; i < 9; i++) begin
      sel_i  = VECS[i].sel;
      lows   = 0;
      btn_ni = 1'b0;
      run(int'(VECS[i].len));
      btn_ni = 1'b1;
      run(REC + 5);
      chk((i == 8) ? "R7 single pulse per hold" : "R6 long press setup", lows, int'(VECS[i].exp));
    end

    // edge fire, short request
    lows = 0; req_i = 1'b1;
    run(1);
    chk("R2 one-cycle latency", rst_no, 0);
    run(2); req_i = 1'b0;
    run(30);
    chk("R2 pulse width", lows, REC);

    // rise inside lockout
    lows = 0; req_i = 1'b1;
    run(2); req_i = 1'b0;
    run(8);
    chk("R4 rise in lockout ignored", lows, 0);

    // after lockout expiry
    lows = 0; req_i = 1'b1;
    run(1);
    chk("R5 fires after lockout", rst_no, 0);
    run(1); req_i = 1'b0;
    run(20);
    chk("R5 pulse width", lows, REC);
    run(40);

    // retrigger during pulse
    lows = 0; req_i = 1'b1;
    run(2); req_i = 1'b0;
    run(3); req_i = 1'b1;
    run(2); req_i = 1'b0;
    run(30);
    chk("R3 no restart", lows, REC);
    run(10);

    // request held past the pulse
    lows = 0; req_i = 1'b1;
    run(30);
    chk("R4 held request pulse width", lows, REC);
    lows = 0; req_i = 1'b0;
    run(19); req_i = 1'b1;
    run(2); req_i = 1'b0;
    run(3);
    chk("R4 lockout from falling edge", lows, 0);
    run(3);
    lows = 0; req_i = 1'b1;
    run(2); req_i = 1'b0;
    run(20);
    chk("R5 fires after late lockout", lows, REC);
    run(40);

    // tick paused
    tick_i = 1'b0; lows = 0; req_i = 1'b1;
    run(2); req_i = 1'b0;
    run(48);
    chk("R9 pulse frozen without tick", lows, 50);
    lows = 0; tick_i = 1'b1;
    run(20);
    chk("R9 pulse resumes with tick", lows, REC - 1);
    run(40);

    // undervoltage
    uv_i = 1'b1;
    #1;
    chk("R8 immediate assert", rst_no, 0);
    run(5);
    uv_i = 1'b0;
    #1;
    lows = (!rst_no) ? 1 : 0;
    run(20);
    chk("R8 hold-off after release", lows, REC);

    // independence while button held
    sel_i = 2'b10; btn_ni = 1'b0;
    run(5);
    lows = 0; req_i = 1'b1;
    run(1);
    chk("R10 edge fires during press", rst_no, 0);
    run(1); req_i = 1'b0;
    run(25);
    chk("R10 edge pulse width during press", lows, REC);
    btn_ni = 1'b1;
    run(40);
    chk("R10 idle after both channels", rst_no, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule